// File: doc/BRIEF.md
# Single-Vector Interrupt Controller with Edge-Selectable External Pin

This block decides when a small processor core leaves its instruction stream for its one interrupt handler. It holds a four-bit control register with a global enable, a peripheral-group enable, an external-pin enable and the external-pin flag. It also receives a second-level enable and a flag from the peripheral group, and an external pin whose active edge is chosen by an input. The pin passes through a two-stage synchroniser and an edge detector. A valid edge sets the external flag whether or not any enable is set.

When the global enable is set and at least one enabled source has its flag raised, the block takes the interrupt. In a single registered cycle it asserts a flush of the prefetched instruction and a PC load to the vector address 0x0004. In the same cycle it clears the global enable and pushes the core's current PC onto an eight-entry circular return stack. A return-from-interrupt strobe pops the stack, loads the popped address into the PC and sets the global enable again, all in one cycle. Software clears flags by writing the control register. A flag that stays set makes the handler run again straight after the return.

Top module: `intc_top`

## Requirements
- R1: While `rst` is high, and after it falls, the control register reads 0, and `irq_take` and `pc_load` are 0.
- R2: `ctl_wr` loads `ctl_wdata` into the control register at the clock edge. The bit positions are 3 global enable, 2 peripheral enable, 1 external enable and 0 external flag. `ctl_rd` shows the new value after that edge.
- R3: `irq_take` goes high for one cycle, one edge after the register state meets the take condition. The condition is: global enable AND ((external enable AND external flag) OR (peripheral enable AND `per_en` AND `per_flag`)). When the condition is not met, no interrupt is taken.
- R4: In the cycle `irq_take` is high, `pc_load` is 1, `pc_target` is 0x0004 and the global enable reads 0. The `pc_in` value present at the deciding edge is pushed onto the return stack.
- R5: A valid pin edge sets the external flag even when the global and external enables are 0. No interrupt follows.
- R6: With `edge_rise` at 1 only a rising pin edge sets the flag; with `edge_rise` at 0 only a falling edge does.
- R7: A peripheral request is taken at the first edge after `per_flag` rises. For a pin change made before edge n, the external flag reads 1 after edge n+2 and `irq_take` is high after edge n+3.
- R8: `reti` causes `pc_load` to be 1 at the next edge, with `pc_target` equal to the newest unpopped stack entry and the global enable reading 1. If a take would fall in that same cycle, `reti` wins and no take happens.
- R9: If an enabled flag is still set when `reti` completes, the interrupt is taken again one edge later.
- R10: The return stack holds 8 entries and wraps. After nine pushes, pops return the ninth, eighth, …, second pushed values in that order, and a ninth pop returns the ninth value again.
- R11: Software clears a flag by writing 0 to it. With the flag cleared, or with its enable at 0, a raised source is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control register write data |
| ctl_rd | output | 4 | Control register contents |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1 selects rising edge, 0 selects falling edge |
| per_flag | input | 1 | Peripheral interrupt flag |
| per_en | input | 1 | Peripheral second-level enable |
| pc_in | input | 13 | Current program counter of the core |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_take | output | 1 | Interrupt taken; flush the prefetched instruction |
| pc_load | output | 1 | Load `pc_target` into the PC |
| pc_target | output | 13 | Vector address or return address |

## Verification
Each result arrives at a fixed, known edge. A register write and a peripheral take each appear one edge after their cause. A `reti` shows its pop and its restored global enable one edge after the strobe, and any re-entry follows one edge later. A pin change shows up in the flag after three edges and in `irq_take` after four. The bench drives every input on the falling clock edge and samples outputs at the falling edge after each rising edge. It counts exactly those edges before each compare. The latency checks compare at the edge before the expected change as well as at the edge of the change, so a result that comes early or late shows up as a mismatch.

// File: rtl/intc_pkg.sv
package intc_pkg;

    parameter int PC_W        = 13;
    parameter int STACK_DEPTH = 8;
    parameter int SYNC_STAGES = 2;
    localparam int SP_W       = $clog2(STACK_DEPTH);
    localparam int CTL_W      = 4;
    localparam logic [PC_W-1:0] VECTOR_ADDR = PC_W'(4);

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic glb_en;
        logic grp_en;
        logic pin_en;
        logic pin_flag;
    } ctl_t;

    typedef enum logic [1:0] {
        TGT_HOLD,
        TGT_VECTOR,
        TGT_RETURN
    } tgt_sel_e;

    function automatic logic edge_hit(input logic rise_sel, input logic cur, input logic prev);
        return rise_sel ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync
    import intc_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    assign hit = edge_hit(rise_sel, chain[STAGES-1], chain[STAGES]);

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (rst)
        hit |=> (!hit || !$stable(rise_sel))) else $error("edge spacing"); // R6

endmodule

// File: rtl/intc_stack.sv
module intc_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH,
    parameter int W     = PC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_dec;

    assign ptr_dec = ptr - PW'(1);
    assign top     = mem[ptr_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push) begin
            mem[ptr] <= din;
            ptr      <= ptr + PW'(1);
        end else if (pop) begin
            ptr <= ptr_dec;
        end
    end

    AST_STACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)) else $error("push and pop together"); // R10

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rd,
    input  logic             ext_pin,
    input  logic             edge_rise,
    input  logic             per_flag,
    input  logic             per_en,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             reti,
    output logic             irq_take,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_target
);

    ctl_t     ctl_q, ctl_d;
    logic     pin_hit;
    logic     pin_req, grp_req, take_now;
    pc_t      stack_top;
    tgt_sel_e tgt_sel;

    intc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .rise_sel (edge_rise),
        .hit      (pin_hit)
    );

    intc_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (take_now),
        .pop  (reti),
        .din  (pc_in),
        .top  (stack_top)
    );

    assign pin_req  = ctl_q.pin_en & ctl_q.pin_flag;
    assign grp_req  = ctl_q.grp_en & per_en & per_flag;
    assign take_now = ctl_q.glb_en & (pin_req | grp_req) & ~reti;

    always_comb begin
        ctl_d = ctl_wr ? ctl_t'(ctl_wdata) : ctl_q;
        ctl_d.pin_flag = ctl_d.pin_flag | pin_hit;
        if (take_now) ctl_d.glb_en = 1'b0;
        if (reti)     ctl_d.glb_en = 1'b1;
        if (take_now)  tgt_sel = TGT_VECTOR;
        else if (reti) tgt_sel = TGT_RETURN;
        else           tgt_sel = TGT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            irq_take  <= 1'b0;
            pc_load   <= 1'b0;
            pc_target <= '0;
        end else begin
            ctl_q    <= ctl_d;
            irq_take <= take_now;
            pc_load  <= (tgt_sel != TGT_HOLD);
            case (tgt_sel)
                TGT_VECTOR: pc_target <= VECTOR_ADDR;
                TGT_RETURN: pc_target <= stack_top;
                default:    pc_target <= pc_target;
            endcase
        end
    end

    assign ctl_rd = ctl_q;

    AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> $past(ctl_q.glb_en)) else $error("take without enable"); // R3
    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (pc_load && pc_target == VECTOR_ADDR && !ctl_rd[3])) else $error("entry"); // R4
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take) else $error("take not a pulse"); // R4
    AST_RETI_RESTORE: assert property (@(posedge clk) disable iff (rst)
        reti |=> (ctl_rd[3] && pc_load && !irq_take)) else $error("return"); // R8

endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
    import intc_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             ctl_wr;
    logic [CTL_W-1:0] ctl_wdata;
    logic [CTL_W-1:0] ctl_rd;
    logic             ext_pin, edge_rise, per_flag, per_en, reti;
    logic [PC_W-1:0]  pc_in;
    logic             irq_take, pc_load;
    logic [PC_W-1:0]  pc_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    intc_top u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
        .ext_pin(ext_pin), .edge_rise(edge_rise), .per_flag(per_flag), .per_en(per_en),
        .pc_in(pc_in), .reti(reti), .irq_take(irq_take), .pc_load(pc_load),
        .pc_target(pc_target)
    );

    // {gie, pie, xie, xflag, per_en, per_flag, expected take}
    localparam logic [6:0] VEC [10] = '{
        7'b1111_00_1, 7'b0111_11_0, 7'b1011_00_1, 7'b1001_00_0, 7'b1010_00_0,
        7'b1100_11_1, 7'b1000_11_0, 7'b1100_01_0, 7'b1100_10_0, 7'b1110_01_0
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        cyc();
        ctl_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0; ext_pin = 1'b0; edge_rise = 1'b1;
        per_flag = 1'b0; per_en = 1'b0; pc_in = '0; reti = 1'b0;
        @(negedge clk);
        repeat (3) cyc();
        check("R1 ctl", ctl_rd, 0);
        check("R1 take", irq_take, 0);
        check("R1 load", pc_load, 0);
        rst = 1'b0;
        cyc();
        check("R1 ctl after release", ctl_rd, 0);

        // R2 readback
        wr_ctl(4'b0110);
        check("R2 readback", ctl_rd, 4'h6);
        wr_ctl(4'b0000);

        // R3 and R11 condition table
        for (int i = 0; i < 10; i++) begin
            per_en = VEC[i][2]; per_flag = VEC[i][1];
            wr_ctl(VEC[i][6:3]);
            cyc();
            check($sformatf("R3 R11 vector %0d take", i), irq_take, VEC[i][0]);
            if (VEC[i][0]) begin
                check("R4 vector", pc_target, 4);
                check("R4 gie cleared", ctl_rd[3], 0);
                check("R4 load", pc_load, 1);
            end
            per_flag = 1'b0; per_en = 1'b0;
            wr_ctl(4'b0000);
        end

        // R5 R6 R7: rising edge sets flag with everything disabled
        edge_rise = 1'b1;
        ext_pin = 1'b1;
        cyc(); check("R7 flag e1", ctl_rd[0], 0);
        cyc(); check("R7 flag e2", ctl_rd[0], 0);
        cyc(); check("R5 flag set while disabled", ctl_rd[0], 1);
        cyc(); check("R5 no take", irq_take, 0);
        wr_ctl(4'b0000);
        ext_pin = 1'b0;
        repeat (5) cyc();
        check("R6 falling ignored when rise selected", ctl_rd[0], 0);
        edge_rise = 1'b0;
        repeat (3) cyc();
        ext_pin = 1'b1;
        repeat (5) cyc();
        check("R6 rising ignored when fall selected", ctl_rd[0], 0);
        ext_pin = 1'b0;
        repeat (5) cyc();
        check("R6 falling sets flag", ctl_rd[0], 1);
        wr_ctl(4'b0000);
        edge_rise = 1'b1;
        repeat (3) cyc();

        // R7 external latency with take, R4 push
        pc_in = 13'h123;
        wr_ctl(4'b1010);
        ext_pin = 1'b1;
        cyc(); cyc();
        cyc(); check("R7 flag at n+2", ctl_rd[0], 1);
        check("R7 no take at n+2", irq_take, 0);
        cyc(); check("R7 take at n+3", irq_take, 1);
        check("R4 target", pc_target, 4);
        check("R4 gie", ctl_rd[3], 0);

        // R8 return, R9 re-entry
        reti = 1'b1;
        cyc();
        reti = 1'b0;
        check("R8 load", pc_load, 1);
        check("R8 popped pc", pc_target, 13'h123);
        check("R8 gie set", ctl_rd[3], 1);
        check("R8 no take with reti", irq_take, 0);
        cyc();
        check("R9 re-entry", irq_take, 1);

        // R11 cleared flag, no re-entry
        wr_ctl(4'b0010);
        reti = 1'b1;
        cyc();
        reti = 1'b0;
        check("R11 gie after reti", ctl_rd[3], 1);
        cyc();
        check("R11 cleared flag no take", irq_take, 0);
        ext_pin = 1'b0;
        wr_ctl(4'b0000);

        // R7 peripheral latency
        per_en = 1'b1;
        wr_ctl(4'b1100);
        per_flag = 1'b1;
        cyc();
        check("R7 peripheral take after one edge", irq_take, 1);
        per_flag = 1'b0;

        // R10 stack wrap
        rst = 1'b1; cyc(); rst = 1'b0;
        per_en = 1'b1;
        for (int i = 0; i < 9; i++) begin
            pc_in = 13'h100 + 13'(i);
            per_flag = 1'b1;
            wr_ctl(4'b1100);
            cyc();
            check("R10 push take", irq_take, 1);
        end
        per_flag = 1'b0;
        reti = 1'b1;
        for (int j = 0; j < 9; j++) begin
            cyc();
            check($sformatf("R10 pop %0d", j), pc_target,
                  (j == 0 || j == 8) ? 13'h108 : 13'h108 - 13'(j));
        end
        reti = 1'b0;
        cyc();

        finish_run();
    end

endmodule